// File: doc/BRIEF.md
# Linear CCD Clock Timing Generator

This block derives every digital drive pulse of a two-channel linear CCD sensor from one fast system clock. Each line begins with a lead guard, a readout-gate pulse and a trail guard, all with the transfer clocks parked. It then runs a programmable number of transfer cycles. In each cycle the two complementary transfer phases toggle once, and a hold pulse, a reset pulse and a clamp pulse are placed inside the cycle. One full set of these clocks is produced for the odd channel and one for the even channel.

In simultaneous mode the two sets are identical. In alternate mode the whole even set runs half a transfer cycle behind the odd set. The next line's lead guard waits until the later channel has finished. Downstream sampling logic receives a one-tick line-start strobe and a one-tick pixel strobe for each channel. A start pulse begins continuous line generation. A stop pulse ends it once the line in progress is complete.

All pulse widths, guards and the half transfer period are configuration inputs counted in system-clock ticks. A field of zero selects the recommended value. A field below its minimum is raised to that minimum.

Top module: `ccd_line_clkgen`

## Requirements
- R1: During reset, and afterwards until start is pulsed, rd_gate, every hold, reset-pulse and clamp output and both pixel strobes are 0, line_start is 0, ck_a_* is 1 and ck_b_* is 0.
- R2: After start is sampled, rd_gate rises exactly lead+1 ticks later and stays high for exactly gate_w ticks. gate_w is never below 150 ticks.
- R3: Each timing field maps to an effective value. Zero selects the default. A nonzero value below the minimum gives the minimum. Any other value is used as given. Minimum/default values at 250 MHz: half 7/125, gate_w 150/250, lead 13/25, trail 100/250, hold/reset/clamp 3/25, cycles 2622/2622.
- R4: ck_b is always the complement of ck_a. Outside transfer cycles, including the whole gate window and both guards, ck_a is 1. The first ck_a_odd fall comes exactly trail+1 ticks after rd_gate falls.
- R5: A transfer cycle lasts 2*half ticks. ck_a is low for the first half and high for the second. Hold and reset pulses are high for their widths from the cycle's first tick. The clamp pulse is high for its width from the first tick of the high half. Hold, reset and clamp widths are capped at half.
- R6: Each line holds exactly max(cycles, 2622) transfer cycles per channel. Each pixel strobe pulses once per cycle of its channel, on the tick its ck_a falls.
- R7: With alt_mode=0 every even output equals its odd counterpart on every tick.
- R8: With alt_mode=1 every even output is the odd output delayed by exactly half ticks.
- R9: rd_gate rises no sooner than lead ticks after the last ck_a edge of either channel. Lines repeat back to back while no stop is pending.
- R10: line_start is a one-tick pulse once per line, high on the tick just before the line's first ck_a_odd fall.
- R11: A stop pulse lets the current line finish. No further rd_gate pulse follows, and the clocks stay parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin continuous line generation |
| stop | input | 1 | Pulse to stop after the current line |
| alt_mode | input | 1 | 1 delays the even set by half a transfer cycle |
| cfg_half | input | 16 | Half transfer period, ticks |
| cfg_gate_w | input | 16 | Readout-gate high time, ticks |
| cfg_lead | input | 16 | Guard before the gate rises, ticks |
| cfg_trail | input | 16 | Guard after the gate falls, ticks |
| cfg_hold_w | input | 16 | Hold pulse width, ticks |
| cfg_rstp_w | input | 16 | Reset pulse width, ticks |
| cfg_clamp_w | input | 16 | Clamp pulse width, ticks |
| cfg_cycles | input | 16 | Transfer cycles per line |
| rd_gate | output | 1 | Readout-gate pulse |
| ck_a_odd | output | 1 | Odd transfer phase A |
| ck_b_odd | output | 1 | Odd transfer phase B |
| hold_odd | output | 1 | Odd last-stage hold |
| rstp_odd | output | 1 | Odd reset pulse |
| clamp_odd | output | 1 | Odd clamp pulse |
| ck_a_evn | output | 1 | Even transfer phase A |
| ck_b_evn | output | 1 | Even transfer phase B |
| hold_evn | output | 1 | Even last-stage hold |
| rstp_evn | output | 1 | Even reset pulse |
| clamp_evn | output | 1 | Even clamp pulse |
| line_start | output | 1 | One-tick strobe before the first transfer of a line |
| pix_vld_odd | output | 1 | One-tick strobe per odd transfer cycle |
| pix_vld_evn | output | 1 | One-tick strobe per even transfer cycle |

## Verification
A wrong sequencer state shows up as a readout-gate pulse of the wrong length, or as a guard whose tick count is off by one or more. It is visible at the first line, within a few hundred ticks of start. A wrong channel counter changes the measured phase widths, or puts a hold, reset or clamp pulse in the wrong half of the first transfer cycle. It can also show as an even set that neither matches nor lags the odd set by exactly half. Faults in the cycle count or in the stop handling appear only at the end of a line, as a wrong count of falling edges and strobes, or as a third gate pulse after a stop.

// File: rtl/ccdtg_pkg.sv
package ccdtg_pkg;

  typedef enum logic [2:0] {SQ_IDLE, SQ_LEAD, SQ_GATE, SQ_TRAIL, SQ_XFER} seq_st_e;

  // nanoseconds to system ticks, rounded up
  function automatic int unsigned ns_to_ticks(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // zero picks the default, small values are raised to the floor
  function automatic int unsigned pick_eff(input int unsigned raw, input int unsigned dflt,
                                           input int unsigned lo);
    if (raw == 0) return dflt;
    else if (raw < lo) return lo;
    else return raw;
  endfunction

  function automatic int unsigned cap_to(input int unsigned v, input int unsigned hi);
    return (v > hi) ? hi : v;
  endfunction

endpackage

// File: rtl/ccdtg_chan.sv
module ccdtg_chan #(
  parameter int TW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [TW-1:0] dly,
  input  logic [TW-1:0] half,
  input  logic [TW-1:0] hold_w,
  input  logic [TW-1:0] rstp_w,
  input  logic [TW-1:0] clamp_w,
  input  logic [CW-1:0] ncyc,
  output logic          ck_a,
  output logic          ck_b,
  output logic          hold,
  output logic          rstp,
  output logic          clamp,
  output logic          pix_vld,
  output logic          busy
);
  logic          active;
  logic [TW-1:0] wcnt, h_l, hw_l, rw_l, cw_l;
  logic [TW:0]   tick;
  logic [CW-1:0] cyc, nc_l;

  // named internal events
  logic run, tick_last, cyc_last, second_half;
  logic a_n, hold_n, rstp_n, clamp_n, vld_n;

  assign run         = active && (wcnt == '0);
  assign tick_last   = tick == ({h_l, 1'b0} - (TW+1)'(1));
  assign cyc_last    = cyc == (nc_l - CW'(1));
  assign second_half = tick >= {1'b0, h_l};

  assign a_n     = run ? second_half : 1'b1;
  assign hold_n  = run && (tick < {1'b0, hw_l});
  assign rstp_n  = run && (tick < {1'b0, rw_l});
  assign clamp_n = run && second_half && ((tick - {1'b0, h_l}) < {1'b0, cw_l});
  assign vld_n   = run && (tick == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wcnt   <= '0;
      tick   <= '0;
      cyc    <= '0;
      h_l    <= '0;
      hw_l   <= '0;
      rw_l   <= '0;
      cw_l   <= '0;
      nc_l   <= '0;
      ck_a   <= 1'b1;
      ck_b   <= 1'b0;
      hold   <= 1'b0;
      rstp   <= 1'b0;
      clamp  <= 1'b0;
      pix_vld <= 1'b0;
    end else begin
      if (go && !active) begin
        active <= 1'b1;
        wcnt   <= dly;
        tick   <= '0;
        cyc    <= '0;
        h_l    <= half;
        hw_l   <= hold_w;
        rw_l   <= rstp_w;
        cw_l   <= clamp_w;
        nc_l   <= ncyc;
      end else if (active) begin
        if (wcnt != '0) wcnt <= wcnt - TW'(1);
        else if (tick_last) begin
          tick <= '0;
          if (cyc_last) active <= 1'b0;
          else cyc <= cyc + CW'(1);
        end else tick <= tick + (TW+1)'(1);
      end
      ck_a    <= a_n;
      ck_b    <= !a_n;
      hold    <= hold_n;
      rstp    <= rstp_n;
      clamp   <= clamp_n;
      pix_vld <= vld_n;
    end
  end

  assign busy = active;

  p_vld_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld |-> $fell(ck_a));
  p_rstp_clamp_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rstp |-> !clamp);
  p_hold_in_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ck_b);

endmodule

// File: rtl/ccdtg_seq.sv
module ccdtg_seq
  import ccdtg_pkg::*;
#(
  parameter int TW      = 16,
  parameter int MIN_GATE = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [TW-1:0] lead_t,
  input  logic [TW-1:0] gate_t,
  input  logic [TW-1:0] trail_t,
  input  logic          xfer_busy,
  output logic          gate,
  output logic          go,
  output logic          line_start
);
  seq_st_e       st;
  logic [TW-1:0] cnt;
  logic          stop_pend;
  logic          cnt_done, line_done;
  logic [TW:0]   gate_len;

  assign cnt_done  = cnt == '0;
  assign line_done = (st == SQ_XFER) && !go && !xfer_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      cnt        <= '0;
      stop_pend  <= 1'b0;
      go         <= 1'b0;
      gate       <= 1'b0;
      line_start <= 1'b0;
    end else begin
      go <= 1'b0;
      unique case (st)
        SQ_IDLE:  if (start) begin st <= SQ_LEAD; cnt <= lead_t - TW'(1); end
        SQ_LEAD:  if (cnt_done) begin st <= SQ_GATE; cnt <= gate_t - TW'(1); end
                  else cnt <= cnt - TW'(1);
        SQ_GATE:  if (cnt_done) begin st <= SQ_TRAIL; cnt <= trail_t - TW'(1); end
                  else cnt <= cnt - TW'(1);
        SQ_TRAIL: if (cnt_done) begin st <= SQ_XFER; go <= 1'b1; end
                  else cnt <= cnt - TW'(1);
        SQ_XFER:  if (line_done) begin
                    if (stop_pend || stop) st <= SQ_IDLE;
                    else begin st <= SQ_LEAD; cnt <= lead_t - TW'(1); end
                  end
        default:  st <= SQ_IDLE;
      endcase
      if (st == SQ_IDLE) stop_pend <= 1'b0;
      else if (stop)     stop_pend <= 1'b1;
      gate       <= (st == SQ_GATE);
      line_start <= go;
    end
  end

  // checker-side run length of the gate pulse
  always_ff @(posedge clk) begin
    if (!rst_n) gate_len <= '0;
    else gate_len <= gate ? gate_len + (TW+1)'(1) : '0;
  end

  p_gate_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> gate_len >= (TW+1)'(MIN_GATE));

endmodule

// File: rtl/ccd_line_clkgen.sv
module ccd_line_clkgen
  import ccdtg_pkg::*;
#(
  parameter int SYS_MHZ  = 250,
  parameter int TW       = 16,
  parameter int CW       = 16,
  parameter int MIN_CYC  = 2622
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          alt_mode,
  input  logic [TW-1:0] cfg_half,
  input  logic [TW-1:0] cfg_gate_w,
  input  logic [TW-1:0] cfg_lead,
  input  logic [TW-1:0] cfg_trail,
  input  logic [TW-1:0] cfg_hold_w,
  input  logic [TW-1:0] cfg_rstp_w,
  input  logic [TW-1:0] cfg_clamp_w,
  input  logic [CW-1:0] cfg_cycles,
  output logic          rd_gate,
  output logic          ck_a_odd,
  output logic          ck_b_odd,
  output logic          hold_odd,
  output logic          rstp_odd,
  output logic          clamp_odd,
  output logic          ck_a_evn,
  output logic          ck_b_evn,
  output logic          hold_evn,
  output logic          rstp_evn,
  output logic          clamp_evn,
  output logic          line_start,
  output logic          pix_vld_odd,
  output logic          pix_vld_evn
);
  localparam int unsigned MIN_HALF  = ns_to_ticks(25,   SYS_MHZ);
  localparam int unsigned DEF_HALF  = ns_to_ticks(500,  SYS_MHZ);
  localparam int unsigned MIN_GATE  = ns_to_ticks(600,  SYS_MHZ);
  localparam int unsigned DEF_GATE  = ns_to_ticks(1000, SYS_MHZ);
  localparam int unsigned MIN_LEAD  = ns_to_ticks(50,   SYS_MHZ);
  localparam int unsigned DEF_LEAD  = ns_to_ticks(100,  SYS_MHZ);
  localparam int unsigned MIN_TRAIL = ns_to_ticks(400,  SYS_MHZ);
  localparam int unsigned DEF_TRAIL = ns_to_ticks(1000, SYS_MHZ);
  localparam int unsigned MIN_PW    = ns_to_ticks(10,   SYS_MHZ);
  localparam int unsigned DEF_PW    = ns_to_ticks(100,  SYS_MHZ);

  logic [TW-1:0] half_e, gate_e, lead_e, trail_e, hold_e, rstp_e, clamp_e;
  logic [CW-1:0] cyc_e;

  assign half_e  = TW'(pick_eff(32'(cfg_half),  DEF_HALF,  MIN_HALF));
  assign gate_e  = TW'(pick_eff(32'(cfg_gate_w), DEF_GATE, MIN_GATE));
  assign lead_e  = TW'(pick_eff(32'(cfg_lead),  DEF_LEAD,  MIN_LEAD));
  assign trail_e = TW'(pick_eff(32'(cfg_trail), DEF_TRAIL, MIN_TRAIL));
  assign hold_e  = TW'(cap_to(pick_eff(32'(cfg_hold_w),  DEF_PW, MIN_PW), 32'(half_e)));
  assign rstp_e  = TW'(cap_to(pick_eff(32'(cfg_rstp_w),  DEF_PW, MIN_PW), 32'(half_e)));
  assign clamp_e = TW'(cap_to(pick_eff(32'(cfg_clamp_w), DEF_PW, MIN_PW), 32'(half_e)));
  assign cyc_e   = CW'(pick_eff(32'(cfg_cycles), MIN_CYC, MIN_CYC));

  logic       go;
  logic [1:0] ch_busy, ck_a, ck_b, hold, rstp, clamp, vld;

  ccdtg_seq #(.TW(TW), .MIN_GATE(MIN_GATE)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .lead_t(lead_e), .gate_t(gate_e), .trail_t(trail_e),
    .xfer_busy(|ch_busy), .gate(rd_gate), .go(go), .line_start(line_start)
  );

  // index 0 is the odd channel, index 1 the even channel
  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [TW-1:0] dly;
    assign dly = (g == 1 && alt_mode) ? half_e : '0;
    ccdtg_chan #(.TW(TW), .CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .go(go), .dly(dly), .half(half_e),
      .hold_w(hold_e), .rstp_w(rstp_e), .clamp_w(clamp_e), .ncyc(cyc_e),
      .ck_a(ck_a[g]), .ck_b(ck_b[g]), .hold(hold[g]), .rstp(rstp[g]),
      .clamp(clamp[g]), .pix_vld(vld[g]), .busy(ch_busy[g])
    );
  end

  assign {ck_a_evn, ck_a_odd}     = ck_a;
  assign {ck_b_evn, ck_b_odd}     = ck_b;
  assign {hold_evn, hold_odd}     = hold;
  assign {rstp_evn, rstp_odd}     = rstp;
  assign {clamp_evn, clamp_odd}   = clamp;
  assign {pix_vld_evn, pix_vld_odd} = vld;

  // guard-time observers: ticks since a transfer edge, ticks since the gate
  logic          a_odd_d, a_evn_d, xfer_edge;
  logic [TW-1:0] quiet_cnt, since_gate;
  assign xfer_edge = (ck_a_odd != a_odd_d) || (ck_a_evn != a_evn_d);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_odd_d    <= 1'b1;
      a_evn_d    <= 1'b1;
      quiet_cnt  <= '0;
      since_gate <= '0;
    end else begin
      a_odd_d <= ck_a_odd;
      a_evn_d <= ck_a_evn;
      if (xfer_edge) quiet_cnt <= '0;
      else if (quiet_cnt != '1) quiet_cnt <= quiet_cnt + TW'(1);
      if (rd_gate) since_gate <= '0;
      else if (since_gate != '1) since_gate <= since_gate + TW'(1);
    end
  end

  p_gate_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_gate |-> (ck_a_odd && !ck_b_odd && ck_a_evn && !ck_b_evn));
  p_lead_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_gate) |-> quiet_cnt >= TW'(MIN_LEAD));
  p_trail_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ck_a_odd) |-> since_gate >= TW'(MIN_TRAIL));

endmodule

// File: tb/tb_ccd_line_clkgen.sv
module tb_ccd_line_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0, start = 1'b0, stop = 1'b0, alt_mode = 1'b0;
  logic [15:0] cfg_half = '0, cfg_gate_w = '0, cfg_lead = '0, cfg_trail = '0;
  logic [15:0] cfg_hold_w = '0, cfg_rstp_w = '0, cfg_clamp_w = '0, cfg_cycles = '0;
  logic rd_gate, ck_a_odd, ck_b_odd, hold_odd, rstp_odd, clamp_odd;
  logic ck_a_evn, ck_b_evn, hold_evn, rstp_evn, clamp_evn;
  logic line_start, pix_vld_odd, pix_vld_evn;

  always #2 clk = ~clk;

  ccd_line_clkgen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .alt_mode(alt_mode),
    .cfg_half(cfg_half), .cfg_gate_w(cfg_gate_w), .cfg_lead(cfg_lead),
    .cfg_trail(cfg_trail), .cfg_hold_w(cfg_hold_w), .cfg_rstp_w(cfg_rstp_w),
    .cfg_clamp_w(cfg_clamp_w), .cfg_cycles(cfg_cycles),
    .rd_gate(rd_gate), .ck_a_odd(ck_a_odd), .ck_b_odd(ck_b_odd),
    .hold_odd(hold_odd), .rstp_odd(rstp_odd), .clamp_odd(clamp_odd),
    .ck_a_evn(ck_a_evn), .ck_b_evn(ck_b_evn), .hold_evn(hold_evn),
    .rstp_evn(rstp_evn), .clamp_evn(clamp_evn), .line_start(line_start),
    .pix_vld_odd(pix_vld_odd), .pix_vld_evn(pix_vld_evn)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // columns: raw half,gate,lead,trail,hold,rstp,clamp,alt | expected half,gate,lead,trail,hold,rstp,clamp
  localparam int NROW = 6;
  localparam int TBL [NROW][15] = '{
    '{ 0,   0,  0,   0,  0, 0, 0, 0,  125, 250, 25, 250, 25, 25, 25},
    '{ 1,   1,  1,   1,  1, 1, 1, 0,    7, 150, 13, 100,  3,  3,  3},
    '{10, 200, 20, 120,  4, 5, 6, 1,   10, 200, 20, 120,  4,  5,  6},
    '{ 9, 151, 14, 101, 50, 2, 9, 0,    9, 151, 14, 101,  9,  3,  9},
    '{ 8, 149, 12,  99,  0, 8, 3, 1,    8, 150, 13, 100,  8,  8,  3},
    '{20,   0,  0,   0,  7, 7, 7, 0,   20, 250, 25, 250,  7,  7,  7}
  };

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_row(input int r);
    int c = 0, w = 0, g = 0, lo = 0, hi = 0, ls_cnt = 0, ls_prev = 0;
    int rs_n = 0, hl_n = 0, cl_n = 0, cl_bad = 0, rs_bad = 0, hl_bad = 0;
    int park_bad = 0, cmp_bad = 0, sim_bad = 0, e_hi = 0, e_lo = 0;
    cfg_half = 16'(TBL[r][0]); cfg_gate_w = 16'(TBL[r][1]); cfg_lead = 16'(TBL[r][2]);
    cfg_trail = 16'(TBL[r][3]); cfg_hold_w = 16'(TBL[r][4]); cfg_rstp_w = 16'(TBL[r][5]);
    cfg_clamp_w = 16'(TBL[r][6]); alt_mode = TBL[r][7][0]; cfg_cycles = '0;
    do_reset();
    pulse_start();
    while (!rd_gate) begin
      if (!ck_a_odd || ck_b_odd) park_bad++;
      @(negedge clk); c++;
    end
    while (rd_gate) begin
      if (!ck_a_odd || ck_b_odd || !ck_a_evn || ck_b_evn) park_bad++;
      @(negedge clk); w++;
    end
    while (ck_a_odd) begin
      ls_prev = line_start;
      if (line_start) ls_cnt++;
      @(negedge clk); g++;
    end
    chk($sformatf("R2 lead row%0d", r), c, TBL[r][10] + 1);
    chk($sformatf("R2 R3 gate width row%0d", r), w, TBL[r][9]);
    chk($sformatf("R4 trail row%0d", r), g, TBL[r][11] + 1);
    chk($sformatf("R4 parked during guards row%0d", r), park_bad, 0);
    chk($sformatf("R10 line_start before fall row%0d", r), ls_prev, 1);
    chk($sformatf("R10 line_start once row%0d", r), ls_cnt, 1);
    chk($sformatf("R6 pixel strobe on fall row%0d", r), int'(pix_vld_odd), 1);
    while (!ck_a_odd) begin
      lo++;
      if (rstp_odd) rs_n++;
      if (hold_odd) hl_n++;
      if (clamp_odd) cl_bad++;
      if (ck_b_odd == ck_a_odd) cmp_bad++;
      if (ck_a_evn) e_hi++;
      if ({ck_a_evn, ck_b_evn, hold_evn, rstp_evn, clamp_evn, pix_vld_evn} !=
          {ck_a_odd, ck_b_odd, hold_odd, rstp_odd, clamp_odd, pix_vld_odd}) sim_bad++;
      @(negedge clk);
    end
    while (ck_a_odd) begin
      hi++;
      if (clamp_odd) cl_n++;
      if (rstp_odd) rs_bad++;
      if (hold_odd) hl_bad++;
      if (ck_b_odd == ck_a_odd) cmp_bad++;
      if (!ck_a_evn) e_lo++;
      if ({ck_a_evn, ck_b_evn, hold_evn, rstp_evn, clamp_evn, pix_vld_evn} !=
          {ck_a_odd, ck_b_odd, hold_odd, rstp_odd, clamp_odd, pix_vld_odd}) sim_bad++;
      @(negedge clk);
    end
    chk($sformatf("R5 R3 low half row%0d", r), lo, TBL[r][8]);
    chk($sformatf("R5 high half row%0d", r), hi, TBL[r][8]);
    chk($sformatf("R5 R3 reset width row%0d", r), rs_n, TBL[r][13]);
    chk($sformatf("R5 R3 hold width row%0d", r), hl_n, TBL[r][12]);
    chk($sformatf("R5 R3 clamp width row%0d", r), cl_n, TBL[r][14]);
    chk($sformatf("R5 pulses in own half row%0d", r), cl_bad + rs_bad + hl_bad, 0);
    chk($sformatf("R4 complement row%0d", r), cmp_bad, 0);
    if (TBL[r][7] == 0) chk($sformatf("R7 sets equal row%0d", r), sim_bad, 0);
    else begin
      chk($sformatf("R8 even lag in low half row%0d", r), e_hi, TBL[r][8]);
      chk($sformatf("R8 even lag in high half row%0d", r), e_lo, TBL[r][8]);
    end
  endtask

  // line-level monitor
  int rises, tog_gate, quiet, q_at2;
  int fo[4], fe[4], vo[4], ve[4], lsn[4];

  task automatic run_lines(input int nt, input int stop_rise);
    bit po, pe, pg;
    rises = 0; tog_gate = 0; quiet = 0; q_at2 = -1;
    for (int k = 0; k < 4; k++) begin fo[k] = 0; fe[k] = 0; vo[k] = 0; ve[k] = 0; lsn[k] = 0; end
    po = ck_a_odd; pe = ck_a_evn; pg = rd_gate;
    for (int t = 0; t < nt; t++) begin
      int idx;
      @(negedge clk);
      start = 1'b0; stop = 1'b0;
      if (rd_gate && !pg) begin
        rises++;
        if (rises == 2) q_at2 = quiet;
        if (rises == stop_rise) stop = 1'b1;
      end
      if (ck_a_odd != po || ck_a_evn != pe) begin
        if (rd_gate) tog_gate++;
        quiet = 0;
      end else quiet++;
      idx = (rises > 3) ? 3 : rises;
      if (!ck_a_odd && po) fo[idx]++;
      if (!ck_a_evn && pe) fe[idx]++;
      if (pix_vld_odd) vo[idx]++;
      if (pix_vld_evn) ve[idx]++;
      if (line_start) lsn[idx]++;
      po = ck_a_odd; pe = ck_a_evn; pg = rd_gate;
    end
  endtask

  initial begin
    // R1: reset state and quiet before start
    cfg_half = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset",
        int'({rd_gate, ck_a_odd, ck_b_odd, hold_odd, rstp_odd, clamp_odd,
              ck_a_evn, ck_b_evn, hold_evn, rstp_evn, clamp_evn,
              line_start, pix_vld_odd, pix_vld_evn}), int'(14'b01000010000000));
    rst_n = 1'b1;
    repeat (60) @(negedge clk);
    chk("R1 idle without start",
        int'({rd_gate, ck_a_odd, ck_b_odd, hold_odd, rstp_odd, clamp_odd,
              ck_a_evn, ck_b_evn, hold_evn, rstp_evn, clamp_evn,
              line_start, pix_vld_odd, pix_vld_evn}), int'(14'b01000010000000));

    for (int r = 0; r < NROW; r++) run_row(r);

    // two alternate-mode lines at the floors, stop during line 2
    cfg_half = 16'd1; cfg_gate_w = 16'd1; cfg_lead = 16'd1; cfg_trail = 16'd1;
    cfg_hold_w = 16'd1; cfg_rstp_w = 16'd1; cfg_clamp_w = 16'd1; cfg_cycles = 16'd10;
    alt_mode = 1'b1;
    do_reset();
    start = 1'b1;
    run_lines(78000, 2);
    chk("R11 R9 gate pulses with stop in line 2", rises, 2);
    chk("R6 R3 odd cycles line 1", fo[1], 2622);
    chk("R6 odd cycles line 2", fo[2], 2622);
    chk("R6 R8 even cycles line 1", fe[1], 2622);
    chk("R6 even cycles line 2", fe[2], 2622);
    chk("R6 odd strobes line 1", vo[1], 2622);
    chk("R6 even strobes line 2", ve[2], 2622);
    chk("R10 line_start per line", lsn[1] * 10 + lsn[2], 11);
    chk("R4 no toggling under gate", tog_gate, 0);
    chk_rng("R9 lead guard after even finish", q_at2, 13, 28);
    chk("R11 parked after stop", int'({rd_gate, ck_a_odd, ck_b_odd, ck_a_evn}), int'(4'b0101));

    // simultaneous mode, above-floor cycle count, stop in line 1
    cfg_cycles = 16'd3000; alt_mode = 1'b0;
    do_reset();
    start = 1'b1;
    run_lines(43500, 1);
    chk("R11 single line after stop", rises, 1);
    chk("R6 R3 cycles above floor odd", fo[1], 3000);
    chk("R6 R7 cycles above floor even", fe[1], 3000);
    chk("R6 strobes above floor", vo[1] + ve[1], 6000);
    chk("R10 one line_start", lsn[1], 1);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule